// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block places received frames into host memory through a chained ring of descriptors. Software loads the address of the first descriptor. The engine then reads that descriptor from a shared 32-bit memory port. If the descriptor's ownership bit shows that the engine owns it, the engine takes the buffer size, the buffer address and the branch pointer. It accepts one frame from a byte stream and packs the bytes little-endian into the buffer, using 32-bit writes with byte enables. It then writes back a status word that hands the descriptor back to software, and follows the branch pointer to the next descriptor.

When a descriptor is not owned by the engine, the engine reports a no-receive-buffer cause and parks. While parked it issues no memory traffic and holds the frame stream with `rx_ready` low. It leaves the park state when software issues a receive poll demand, or when software loads a new descriptor address. Framing, CRC checking and address matching are done upstream of this block. Their results arrive as flags that are held for the whole frame and taken with its last byte. The block reports each completed frame on one of two one-cycle cause outputs: packet received, or receive error.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: After reset the block is idle. `mem_req`, `rx_ready` and all three cause outputs are 0, and no memory access is made until `base_load` is pulsed.
- R2: `base_load` is accepted while the block is idle or parked. It makes `base_addr` the current descriptor address. A descriptor is read as status at +0, then control at +4, then buffer address at +8, then branch address at +12.
- R3: If status bit 31 (ownership) reads 0, `irq_no_buf` pulses for one cycle and the block parks. While parked it makes no memory access and keeps `rx_ready` low. `rx_poll` makes it read the same status word again.
- R4: Frame byte k is stored at buffer address + k (buffer word aligned, lane k mod 4 of a 32-bit word). A partly filled final word is written with only its filled lanes enabled, and bytes of the buffer outside the stored range keep their contents.
- R5: The status writeback goes to descriptor +0 after the last data write. It has bit 31 cleared, bits 26:16 holding the number of bytes stored (the 4 CRC bytes included), bit 9 (first buffer) and bit 8 (last buffer) set, and bits 30:27, 14 and 10 at 0.
- R6: `rx_err` bits 0..5 (CRC, alignment, FIFO overflow, long, runt, system) go to status bits 1..6. `rx_dst` bits 0..2 (physical, broadcast, multicast) go to status bits 11..13. Status bit 0 is the OR of bits 7:1, and bit 15 (good frame) is its inverse.
- R7: Bytes beyond the buffer size (control bits 10:0) are consumed but not stored. Status bit 7 is set and the length field then equals the buffer size. A size of 0 stores nothing.
- R8: Once the status write completes, exactly one of `irq_rx_ok` (status bit 0 clear) or `irq_rx_err` (bit 0 set) pulses for one cycle.
- R9: After the writeback the branch word becomes the current descriptor address. Reading continues there without software action, so owned descriptors are filled back to back.
- R10: `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack`. Read data is taken in the cycle that `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_load | input | 1 | Load `base_addr` as current descriptor address |
| base_addr | input | 32 | Descriptor address to load |
| rx_poll | input | 1 | Receive poll demand strobe |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of frame |
| rx_err | input | 6 | Upstream error flags, held over the frame |
| rx_dst | input | 3 | Destination class flags, held over the frame |
| rx_ready | output | 1 | Frame byte accepted this cycle when high with `rx_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| irq_rx_ok | output | 1 | Good frame written back |
| irq_rx_err | output | 1 | Errored frame written back |
| irq_no_buf | output | 1 | Descriptor not owned, engine parked |

## Verification
The bench sweeps frame lengths against buffer sizes that are equal, one byte short and a few bytes long, and also a zero size. A packer that lost the partial final word, wrote disabled lanes or ran past the buffer would show changed fill bytes or a wrong length. It walks all 64 error-flag patterns with rotating destination flags: a wrong bit position, or a good-frame bit that did not follow the summary, shows up in the written status. It parks the engine, polls it without arming a descriptor, fills two owned descriptors back to back, and reloads the base while parked. A design that read descriptor words in the wrong order, kept requesting memory while parked, or failed to follow the branch would stall or write to the wrong place.

// File: rtl/rxr_pkg.sv
// Package: shared state type, status-word bit positions and descriptor
// word offsets for the receive descriptor ring writer.
package rxr_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_STAT,
        S_PARK,
        S_RD_CTRL,
        S_RD_BUF,
        S_RD_BR,
        S_RECV,
        S_WR_DATA,
        S_WR_STAT
    } rxr_state_t;

    // Status word layout (fixed: software decodes it)
    localparam int OWN_BIT   = 31;
    localparam int LEN_LSB   = 16;
    localparam int OK_BIT    = 15;
    localparam int DST_LSB   = 11;
    localparam int FIRST_BIT = 9;
    localparam int LAST_BIT  = 8;
    localparam int UNDF_BIT  = 7;
    localparam int ERR_LSB   = 1;
    localparam int SUM_BIT   = 0;
    localparam int N_ERR     = 6;
    localparam int N_DST     = 3;

    // Descriptor word byte offsets
    localparam logic [31:0] OFS_STAT = 32'd0;
    localparam logic [31:0] OFS_CTRL = 32'd4;
    localparam logic [31:0] OFS_BUF  = 32'd8;
    localparam logic [31:0] OFS_BR   = 32'd12;

endpackage

// File: rtl/rxr_byte_packer.sv
// Module: rxr_byte_packer
// Gathers accepted frame bytes into one little-endian word, tracking which
// lanes are filled, the total stored byte count and the index of the word
// being assembled inside the buffer.
// Assumes: push and drain are never high together; drain follows a write of
// the held word; clr starts a new frame.
module rxr_byte_packer #(
    parameter int LEN_W = 11,
    parameter int LANES = 4,
    localparam int LANE_W = $clog2(LANES),
    localparam int WIDX_W = LEN_W - LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 push,
    input  logic                 drain,
    input  logic [7:0]           byte_in,
    output logic [LANES*8-1:0]   word_o,
    output logic [LANES-1:0]     be_o,
    output logic [LEN_W-1:0]     cnt_o,
    output logic [WIDX_W-1:0]    widx_o,
    output logic                 lane_last_o
);

    logic [LANE_W-1:0] lane_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [WIDX_W-1:0] widx_q;

    // Per-lane byte and enable registers
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] byte_q;
        logic       en_q;

        // Capture a byte when it lands in this lane
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                byte_q <= '0;
            end else if (push && lane_q == LANE_W'(g)) begin
                byte_q <= byte_in;
            end
        end

        // Mark the lane filled until the word is written out
        always_ff @(posedge clk) begin
            if (!rst_n || clr || drain) begin
                en_q <= 1'b0;
            end else if (push && lane_q == LANE_W'(g)) begin
                en_q <= 1'b1;
            end
        end

        assign word_o[g*8 +: 8] = byte_q;
        assign be_o[g]          = en_q;
    end

    // Lane pointer, byte count and word index
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lane_q <= '0;
            cnt_q  <= '0;
            widx_q <= '0;
        end else begin
            if (push) begin
                lane_q <= lane_q + 1'b1;
                cnt_q  <= cnt_q + 1'b1;
            end
            if (drain) begin
                widx_q <= widx_q + 1'b1;
            end
        end
    end

    assign cnt_o       = cnt_q;
    assign widx_o      = widx_q;
    assign lane_last_o = (lane_q == LANE_W'(LANES - 1));

    AST_NO_PUSH_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && drain)); // R4
    AST_DRAIN_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        drain |-> (be_o != '0)); // R4

endmodule

// File: rtl/rxr_status_word.sv
// Module: rxr_status_word
// Builds the status word written back to a finished descriptor from the
// stored length, the latched upstream flags and the truncation flag.
// Assumes: LEN_W is at most 11 so the length fits its field.
module rxr_status_word
    import rxr_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0] len,
    input  logic [N_ERR-1:0] err,
    input  logic [N_DST-1:0] dst,
    input  logic             trunc,
    output logic [31:0]      status
);

    logic any_err;

    // Summary of all error causes, truncation included
    always_comb begin
        any_err = (|err) | trunc;
    end

    // Field placement; ownership left clear to hand the descriptor back
    always_comb begin
        status                     = '0;
        status[LEN_LSB +: LEN_W]   = len;
        status[ERR_LSB +: N_ERR]   = err;
        status[UNDF_BIT]           = trunc;
        status[SUM_BIT]            = any_err;
        status[OK_BIT]             = !any_err;
        status[DST_LSB +: N_DST]   = dst;
        status[FIRST_BIT]          = 1'b1;
        status[LAST_BIT]           = 1'b1;
    end

endmodule

// File: rtl/rxr_seq.sv
// Module: rxr_seq
// Sequencer of the ring writer: fetches descriptors, parks on unowned ones,
// steers frame bytes to the packer, issues data and status writes, follows
// the branch pointer and raises the cause pulses.
// Assumes: memory holds each request until ack; read data valid with ack;
// buffer addresses are word aligned.
module rxr_seq
    import rxr_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int LANES = 4,
    localparam int LANE_W = $clog2(LANES),
    localparam int WIDX_W = LEN_W - LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 base_load,
    input  logic [31:0]          base_addr,
    input  logic                 rx_poll,
    input  logic                 rx_valid,
    input  logic                 rx_last,
    input  logic [N_ERR-1:0]     rx_err,
    input  logic [N_DST-1:0]     rx_dst,
    output logic                 rx_ready,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [31:0]          mem_addr,
    output logic [31:0]          mem_wdata,
    output logic [LANES-1:0]     mem_be,
    input  logic                 mem_ack,
    input  logic [31:0]          mem_rdata,
    output logic                 irq_rx_ok,
    output logic                 irq_rx_err,
    output logic                 irq_no_buf,
    output logic                 pk_clr,
    output logic                 pk_push,
    output logic                 pk_drain,
    input  logic [LANES*8-1:0]   pk_word,
    input  logic [LANES-1:0]     pk_be,
    input  logic [LEN_W-1:0]     pk_cnt,
    input  logic [WIDX_W-1:0]    pk_widx,
    input  logic                 pk_lane_last,
    input  logic [31:0]          st_word,
    output logic [N_ERR-1:0]     st_err,
    output logic [N_DST-1:0]     st_dst,
    output logic                 st_trunc
);

    rxr_state_t        state_q, state_d;
    logic [31:0]       cur_q, buf_q, br_q;
    logic [LEN_W-1:0]  size_q;
    logic              done_q, trunc_q;
    logic [N_ERR-1:0]  err_q;
    logic [N_DST-1:0]  dst_q;
    logic              irq_ok_q, irq_err_q, irq_nb_q;
    logic              beat, room, has_data, reload;

    // Stream acceptance and buffer room
    always_comb begin
        rx_ready = (state_q == S_RECV);
        beat     = rx_valid && rx_ready;
        room     = (pk_cnt < size_q);
        pk_push  = beat && room;
        has_data = (pk_be != '0) || pk_push;
        pk_clr   = (state_q == S_RD_BR) && mem_ack;
        pk_drain = (state_q == S_WR_DATA) && mem_ack;
        reload   = base_load && (state_q == S_IDLE || state_q == S_PARK);
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (base_load) state_d = S_RD_STAT;
            S_PARK:    if (base_load || rx_poll) state_d = S_RD_STAT;
            S_RD_STAT: if (mem_ack) state_d = mem_rdata[OWN_BIT] ? S_RD_CTRL : S_PARK;
            S_RD_CTRL: if (mem_ack) state_d = S_RD_BUF;
            S_RD_BUF:  if (mem_ack) state_d = S_RD_BR;
            S_RD_BR:   if (mem_ack) state_d = S_RECV;
            S_RECV: begin
                if (beat && rx_last) begin
                    state_d = has_data ? S_WR_DATA : S_WR_STAT;
                end else if (pk_push && pk_lane_last) begin
                    state_d = S_WR_DATA;
                end
            end
            S_WR_DATA: if (mem_ack) state_d = done_q ? S_WR_STAT : S_RECV;
            S_WR_STAT: if (mem_ack) state_d = S_RD_STAT;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Current descriptor address: loaded by software or taken from branch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (reload) begin
            cur_q <= base_addr;
        end else if (state_q == S_WR_STAT && mem_ack) begin
            cur_q <= br_q;
        end
    end

    // Descriptor fields captured as they are read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            buf_q  <= '0;
            br_q   <= '0;
        end else if (mem_ack) begin
            if (state_q == S_RD_CTRL) size_q <= mem_rdata[LEN_W-1:0];
            if (state_q == S_RD_BUF)  buf_q  <= mem_rdata;
            if (state_q == S_RD_BR)   br_q   <= mem_rdata;
        end
    end

    // Per-frame flags: end seen, truncation, upstream results
    always_ff @(posedge clk) begin
        if (!rst_n || pk_clr) begin
            done_q  <= 1'b0;
            trunc_q <= 1'b0;
            err_q   <= '0;
            dst_q   <= '0;
        end else if (beat) begin
            if (!room) trunc_q <= 1'b1;
            if (rx_last) begin
                done_q <= 1'b1;
                err_q  <= rx_err;
                dst_q  <= rx_dst;
            end
        end
    end

    // Cause pulses, raised the cycle after the deciding access completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_ok_q  <= 1'b0;
            irq_err_q <= 1'b0;
            irq_nb_q  <= 1'b0;
        end else begin
            irq_ok_q  <= (state_q == S_WR_STAT) && mem_ack && !st_word[SUM_BIT];
            irq_err_q <= (state_q == S_WR_STAT) && mem_ack &&  st_word[SUM_BIT];
            irq_nb_q  <= (state_q == S_RD_STAT) && mem_ack && !mem_rdata[OWN_BIT];
        end
    end

    // Memory request decode per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        mem_be    = '1;
        unique case (state_q)
            S_RD_STAT: begin mem_req = 1'b1; mem_addr = cur_q + OFS_STAT; end
            S_RD_CTRL: begin mem_req = 1'b1; mem_addr = cur_q + OFS_CTRL; end
            S_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_q + OFS_BUF;  end
            S_RD_BR:   begin mem_req = 1'b1; mem_addr = cur_q + OFS_BR;   end
            S_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_q + {{(32-LEN_W){1'b0}}, pk_widx, {LANE_W{1'b0}}};
                mem_wdata = pk_word;
                mem_be    = pk_be;
            end
            S_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + OFS_STAT;
                mem_wdata = st_word;
            end
            default: ;
        endcase
    end

    assign irq_rx_ok  = irq_ok_q;
    assign irq_rx_err = irq_err_q;
    assign irq_no_buf = irq_nb_q;
    assign st_err     = err_q;
    assign st_dst     = dst_q;
    assign st_trunc   = trunc_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_NOBUF_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_no_buf |-> (state_q == S_PARK && !mem_req && !rx_ready)); // R3
    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_rx_ok, irq_rx_err, irq_no_buf})); // R8
    AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR_STAT) |-> (pk_cnt <= size_q)); // R7
    AST_WR_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR_DATA) |-> ({pk_widx, {LANE_W{1'b0}}} < size_q)); // R4

endmodule

// File: rtl/rx_desc_ring_writer.sv
// Module: rx_desc_ring_writer
// Top of the receive descriptor ring writer: joins the sequencer, the byte
// packer and the status builder behind one memory port and one frame stream.
// Assumes: a 32-bit memory with request/ack handshake; upstream flags are
// held stable for the whole frame.
module rx_desc_ring_writer
    import rxr_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int LANES = 4,
    localparam int LANE_W = $clog2(LANES),
    localparam int WIDX_W = LEN_W - LANE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         base_load,
    input  logic [31:0]  base_addr,
    input  logic         rx_poll,
    input  logic         rx_valid,
    input  logic [7:0]   rx_data,
    input  logic         rx_last,
    input  logic [5:0]   rx_err,
    input  logic [2:0]   rx_dst,
    output logic         rx_ready,
    output logic         mem_req,
    output logic         mem_we,
    output logic [31:0]  mem_addr,
    output logic [31:0]  mem_wdata,
    output logic [3:0]   mem_be,
    input  logic         mem_ack,
    input  logic [31:0]  mem_rdata,
    output logic         irq_rx_ok,
    output logic         irq_rx_err,
    output logic         irq_no_buf
);

    logic                pk_clr, pk_push, pk_drain, pk_lane_last;
    logic [LANES*8-1:0]  pk_word;
    logic [LANES-1:0]    pk_be;
    logic [LEN_W-1:0]    pk_cnt;
    logic [WIDX_W-1:0]   pk_widx;
    logic [31:0]         st_word;
    logic [N_ERR-1:0]    st_err;
    logic [N_DST-1:0]    st_dst;
    logic                st_trunc;

    rxr_seq #(.LEN_W(LEN_W), .LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .base_load(base_load), .base_addr(base_addr), .rx_poll(rx_poll),
        .rx_valid(rx_valid), .rx_last(rx_last), .rx_err(rx_err), .rx_dst(rx_dst),
        .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_rx_ok(irq_rx_ok), .irq_rx_err(irq_rx_err), .irq_no_buf(irq_no_buf),
        .pk_clr(pk_clr), .pk_push(pk_push), .pk_drain(pk_drain),
        .pk_word(pk_word), .pk_be(pk_be), .pk_cnt(pk_cnt), .pk_widx(pk_widx),
        .pk_lane_last(pk_lane_last),
        .st_word(st_word), .st_err(st_err), .st_dst(st_dst), .st_trunc(st_trunc)
    );

    rxr_byte_packer #(.LEN_W(LEN_W), .LANES(LANES)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .clr(pk_clr), .push(pk_push), .drain(pk_drain), .byte_in(rx_data),
        .word_o(pk_word), .be_o(pk_be), .cnt_o(pk_cnt), .widx_o(pk_widx),
        .lane_last_o(pk_lane_last)
    );

    rxr_status_word #(.LEN_W(LEN_W)) u_stat (
        .len(pk_cnt), .err(st_err), .dst(st_dst), .trunc(st_trunc),
        .status(st_word)
    );

endmodule

// File: tb/tb_rx_desc_ring_writer.sv
module tb_rx_desc_ring_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_load = 1'b0;
    logic [31:0] base_addr = '0;
    logic        rx_poll = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [5:0]  rx_err = '0;
    logic [2:0]  rx_dst = '0;
    logic        rx_ready, mem_req, mem_we, irq_rx_ok, irq_rx_err, irq_no_buf;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rx_desc_ring_writer dut (
        .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_addr(base_addr),
        .rx_poll(rx_poll), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_err(rx_err), .rx_dst(rx_dst), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_rx_ok(irq_rx_ok), .irq_rx_err(irq_rx_err), .irq_no_buf(irq_no_buf)
    );

    // Memory model and monitors
    logic [31:0] mem [0:1023];
    logic        sw_we = 1'b0;
    logic [31:0] sw_addr = '0, sw_data = '0;
    logic        log_clr = 1'b0;
    logic [31:0] rd_log [0:15];
    int          log_n = 0, req_cycles = 0, ready_cycles = 0, hs_bad = 0;
    int          ok_cnt = 0, err_cnt = 0, nb_cnt = 0;
    logic        wait_q = 1'b0;
    logic [31:0] wait_addr = '0;

    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else        mem_ack <= mem_req && !mem_ack;
        if (mem_req && mem_ack && mem_we)
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) mem[mem_addr[11:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
        if (sw_we) mem[sw_addr[11:2]] <= sw_data;
        if (log_clr) log_n <= 0;
        else if (mem_req && mem_ack && !mem_we && log_n < 16) begin
            rd_log[log_n] <= mem_addr;
            log_n <= log_n + 1;
        end
        if (mem_req) req_cycles <= req_cycles + 1;
        if (rx_ready) ready_cycles <= ready_cycles + 1;
        if (rst_n && wait_q && (!mem_req || mem_addr != wait_addr)) hs_bad <= hs_bad + 1;
        wait_q    <= rst_n && mem_req && !mem_ack;
        wait_addr <= mem_addr;
        if (irq_rx_ok)  ok_cnt <= ok_cnt + 1;
        if (irq_rx_err) err_cnt <= err_cnt + 1;
        if (irq_no_buf) nb_cnt <= nb_cnt + 1;
    end

    int n_checks = 0, n_errors = 0;
    int cur_d = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dsc(input int d);
        return 32'h100 + 32'(d) * 32'h20;
    endfunction
    function automatic logic [31:0] bufa(input int d);
        return 32'h800 + 32'(d) * 32'h80;
    endfunction
    function automatic logic [7:0] dbyte(input int i, input int k);
        return 8'(i * 7 + k * 13 + 1);
    endfunction
    function automatic logic [7:0] fbyte(input int i);
        return 8'(i * 3) ^ 8'hC6;
    endfunction
    function automatic logic [7:0] membyte(input logic [31:0] a);
        return mem[a[11:2]][a[1:0]*8 +: 8];
    endfunction
    function automatic logic [31:0] exp_status(input int len, input int size,
                                               input logic [5:0] e, input logic [2:0] d);
        int st;
        logic [6:0] ev;
        logic sum;
        st  = (len < size) ? len : size;
        ev  = {(len > size), e};
        sum = |ev;
        return (32'(st) << 16) | (32'(!sum) << 15) | (32'(d) << 11) | 32'h300
               | (32'(ev) << 1) | 32'(sum);
    endfunction

    task automatic sw_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); sw_we = 1'b1; sw_addr = a; sw_data = d;
        @(negedge clk); sw_we = 1'b0;
    endtask
    task automatic arm(input int d, input int size, input int nd);
        sw_wr(dsc(d) + 4, 32'(size));
        sw_wr(dsc(d) + 8, bufa(d));
        sw_wr(dsc(d) + 12, dsc(nd));
        sw_wr(dsc(d), 32'h8000_0000);
    endtask
    task automatic fill(input int d, input int i);
        for (int w = 0; w < 12; w++) sw_wr(bufa(d) + 32'(w * 4), {4{fbyte(i)}});
    endtask
    task automatic pulse_poll();
        @(negedge clk); rx_poll = 1'b1; @(negedge clk); rx_poll = 1'b0;
    endtask
    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
    endtask
    task automatic send(input int i, input int len, input logic [5:0] e, input logic [2:0] d);
        rx_err = e; rx_dst = d;
        for (int k = 0; k < len; k++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = dbyte(i, k); rx_last = (k == len - 1);
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    endtask
    task automatic wait_done(input int old);
        for (int c = 0; c < 600 && (ok_cnt + err_cnt) <= old; c++) @(negedge clk);
    endtask
    task automatic wait_nb(input int old);
        for (int c = 0; c < 600 && nb_cnt <= old; c++) @(negedge clk);
    endtask

    // Verify one finished descriptor: status word, buffer bytes, cause
    task automatic verify(input int d, input int i, input int len, input int size,
                          input logic [5:0] e, input logic [2:0] dd,
                          input int ok0, input int er0);
        logic [31:0] exp;
        bit good;
        int stored;
        logic [7:0] eb, ab;
        exp = exp_status(len, size, e, dd);
        check(mem[dsc(d) >> 2] == exp,
              (len > size) ? "R7 truncated status" : ((e != 0) ? "R6 status flags" : "R5 status"),
              mem[dsc(d) >> 2], exp);
        stored = (len < size) ? len : size;
        good = 1'b1; eb = '0; ab = '0;
        for (int k = 0; k < 44; k++) begin
            logic [7:0] x;
            x = (k < stored) ? dbyte(i, k) : fbyte(i);
            if (good && membyte(bufa(d) + 32'(k)) != x) begin
                good = 1'b0; eb = x; ab = membyte(bufa(d) + 32'(k));
            end
        end
        check(good, "R4 buffer bytes", {24'd0, ab}, {24'd0, eb});
        if (exp[0]) check(err_cnt == er0 + 1 && ok_cnt == ok0, "R8 error cause",
                          32'(err_cnt - er0), 32'd1);
        else        check(ok_cnt == ok0 + 1 && err_cnt == er0, "R8 ok cause",
                          32'(ok_cnt - ok0), 32'd1);
    endtask

    // One frame into the parked descriptor, then park on the next
    task automatic run_frame(input int i, input int len, input int size,
                             input logic [5:0] e, input logic [2:0] dd, input bit chk_log);
        int d, nd, ok0, er0, nb0;
        d = cur_d; nd = (cur_d + 1) % 4;
        fill(d, i);
        sw_wr(dsc(nd), 32'h0);
        arm(d, size, nd);
        ok0 = ok_cnt; er0 = err_cnt; nb0 = nb_cnt;
        clear_log();
        pulse_poll();
        send(i, len, e, dd);
        wait_done(ok0 + er0);
        verify(d, i, len, size, e, dd, ok0, er0);
        wait_nb(nb0);
        check(nb_cnt == nb0 + 1, "R9 moved to branch and parked", 32'(nb_cnt - nb0), 32'd1);
        if (chk_log) begin
            check(log_n == 5, "R2 read count", 32'(log_n), 32'd5);
            for (int w = 0; w < 4; w++)
                check(rd_log[w] == dsc(d) + 32'(w * 4), "R2 descriptor word order",
                      rd_log[w], dsc(d) + 32'(w * 4));
            check(rd_log[4] == dsc(nd), "R9 branch address used", rd_log[4], dsc(nd));
        end
        cur_d = nd;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int i, nb0, rq0, ok0, er0;
        i = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int w = 0; w < 1024; w++) sw_wr(32'(w * 4), 32'h0);
        @(negedge clk);
        check(mem_req == 1'b0 && rx_ready == 1'b0, "R1 idle after reset",
              {30'd0, mem_req, rx_ready}, 32'd0);
        check(req_cycles == 0 && ok_cnt + err_cnt + nb_cnt == 0, "R1 no access before load",
              32'(req_cycles), 32'd0);

        // Load base onto an unowned descriptor: one status read then park
        clear_log();
        nb0 = nb_cnt;
        @(negedge clk); base_load = 1'b1; base_addr = dsc(0);
        @(negedge clk); base_load = 1'b0;
        wait_nb(nb0);
        check(nb_cnt == nb0 + 1, "R3 no-buffer cause", 32'(nb_cnt - nb0), 32'd1);
        check(log_n == 1 && rd_log[0] == dsc(0), "R2 status read at base", rd_log[0], dsc(0));

        // Parked: stream offered, no access, no acceptance
        rq0 = req_cycles;
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h55;
        repeat (20) @(negedge clk);
        rx_valid = 1'b0;
        check(req_cycles == rq0 && ready_cycles == 0, "R3 quiet while parked",
              32'(req_cycles - rq0), 32'd0);

        // Poll with nothing armed: re-read same status, park again
        clear_log();
        nb0 = nb_cnt;
        pulse_poll();
        wait_nb(nb0);
        check(nb_cnt == nb0 + 1 && rd_log[0] == dsc(0), "R3 poll re-reads status",
              rd_log[0], dsc(0));

        // Length / size sweep
        for (int len = 1; len <= 24; len++) begin
            for (int s = 0; s < 3; s++) begin
                int size;
                size = (s == 0) ? len : ((s == 1) ? len - 1 : len + 3);
                run_frame(i, len, size, 6'd0, 3'(len), (i == 0));
                i++;
            end
        end
        run_frame(i, 3, 0, 6'd0, 3'd1, 1'b0);   // R7 zero-size buffer
        i++;

        // Error and destination flag sweep
        for (int e = 0; e < 64; e++) begin
            run_frame(i, 5, 8, 6'(e), 3'(e), 1'b0);
            i++;
        end

        // Back to back: two owned descriptors, branch followed without poll
        begin
            int d0, d1, d2, nbb;
            d0 = cur_d; d1 = (cur_d + 1) % 4; d2 = (cur_d + 2) % 4;
            fill(d0, i); fill(d1, i + 1);
            sw_wr(dsc(d2), 32'h0);
            arm(d1, 20, d2);
            arm(d0, 20, d1);
            ok0 = ok_cnt; er0 = err_cnt; nbb = nb_cnt;
            pulse_poll();
            send(i, 9, 6'd0, 3'd2);
            wait_done(ok0 + er0);
            verify(d0, i, 9, 20, 6'd0, 3'd2, ok0, er0);
            ok0 = ok_cnt; er0 = err_cnt;
            send(i + 1, 14, 6'd0, 3'd4);
            wait_done(ok0 + er0);
            verify(d1, i + 1, 14, 20, 6'd0, 3'd4, ok0, er0);
            wait_nb(nbb);
            check(nb_cnt == nbb + 1, "R9 back-to-back without extra park",
                  32'(nb_cnt - nbb), 32'd1);
            cur_d = d2; i += 2;
        end

        // Reload base while parked onto a different owned descriptor
        begin
            int k, kn;
            k = (cur_d + 2) % 4; kn = (k + 1) % 4;
            fill(k, i);
            sw_wr(dsc(kn), 32'h0);
            arm(k, 16, kn);
            ok0 = ok_cnt; er0 = err_cnt; nb0 = nb_cnt;
            clear_log();
            @(negedge clk); base_load = 1'b1; base_addr = dsc(k);
            @(negedge clk); base_load = 1'b0;
            send(i, 7, 6'd0, 3'd0);
            wait_done(ok0 + er0);
            check(rd_log[0] == dsc(k), "R2 reload while parked", rd_log[0], dsc(k));
            verify(k, i, 7, 16, 6'd0, 3'd0, ok0, er0);
            wait_nb(nb0);
            cur_d = kn; i++;
        end

        check(hs_bad == 0, "R10 request held until ack", 32'(hs_bad), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule